// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol engine of a byte-addressed nonvolatile memory that sits on a two-wire serial bus as a slave. It runs on a fast system clock. It synchronizes the raw clock and data lines and finds start and stop conditions on the synchronized copies. It pulls the data line low through an open-drain output enable. A transaction opens with a device address byte, which is compared with a fixed family code and three strap inputs. For a write, two word-address bytes follow, and then any number of data bytes. For a read, bytes are streamed out from the current word address for as long as the master acknowledges.

Around the block sit three other parts: a write buffer that takes one pulse per accepted data byte and a commit pulse when the write is closed, a memory read port with a registered one-cycle latency, and a write engine whose busy flag makes the block refuse its device address, so that the master can poll for completion. A hardware protect input blocks all writes. A random read is a write that stops after the word address, followed by a repeated start with the read bit set. The sequence of start, nine clocks, start and stop returns the engine to idle from any state.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) restarts device-address reception from any state, including the middle of a byte, and leaves the word address unchanged. A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The device address byte arrives MSB first: bits 7..4 must be 1010, bits 3..1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). On a match, SDA is held low during the ninth clock.
- R3: On a device address mismatch there is no acknowledge, and SDA stays released through all later clocks until the next start.
- R4: While busy_i is high, a matching device address is not acknowledged. Once busy_i is low, the same address is acknowledged and the transaction continues.
- R5: A write carries the high word-address byte and then the low word-address byte (only the lower ADDR_W-8 bits of the high byte are kept), followed by data bytes. Each byte is acknowledged. Each data byte produces one wr_valid_o pulse carrying its address and data.
- R6: After each data byte written, the lower PAGE_W bits of the word address increment and wrap within the page. The upper bits are kept.
- R7: A stop that follows at least one data byte gives one wr_commit_o pulse. With wp_i high, data bytes are still acknowledged, but no wr_valid_o pulse and no commit are issued.
- R8: A read sends bytes MSB first. The output changes only after SCL falls. Bytes continue while the master acknowledges with 0, and a master non-acknowledge ends the read and releases SDA. A read with no word address given starts at the address after the last byte accessed.
- R9: A sequential read increments across the whole address space and wraps from the top address to 0.
- R10: A repeated start after the word-address bytes of a write, followed by a read address byte, reads from the loaded word address.
- R11: The slave acknowledge is driven from the SCL falling edge after bit 8 until the next falling edge. sda_oe_o changes only after an SCL falling edge, a start or a stop.
- R12: After the sequence start, nine clocks with SDA high, start, stop, the block is idle and serves the next transaction normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (bus level) |
| strap_i | input | 3 | Board straps compared with device address bits 3..1 |
| wp_i | input | 1 | Write protect: high blocks all writes |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rd_addr_o | output | ADDR_W | Current word address, to the memory read port |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_addr_o |
| wr_valid_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr_o | output | ADDR_W | Address of the accepted data byte |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | One-cycle pulse starting the write cycle on stop |

## Verification
A wrong phase or bit count shows up on SDA within one byte. An acknowledge appears where none is due, or is missing, at the ninth clock. Write pulses also arrive with the wrong address or data, and the bench checks them on every clock as they come out. A corrupted word address stays hidden until the next read or write. It then shows as a wrong data byte on the first bit that differs. For this reason every write and abort scenario is followed by a current-address read. A stuck output enable is caught on the first clock of a period in which the slave must stay off the bus.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

  // Protocol phase of the slave engine.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_READ,
    PH_WAIT
  } phase_t;

  // Bit counter values: last data bit and acknowledge slot.
  localparam logic [3:0] BIT_LAST = 4'd7;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  // Device select: family code in the top nibble, straps below, R/W ignored.
  function automatic logic dev_hit(input logic [7:0] b,
                                   input logic [3:0] family,
                                   input logic [2:0] strap);
    return (b[7:4] == family) && (b[3:1] == strap);
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  // Idle bus level is high, so every stage resets to 1.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_o = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/tw_word_addr.sv
`timescale 1ns/1ps
module tw_word_addr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        byte_i,
  input  logic              step_page_i,
  input  logic              step_lin_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - 8;

  // Increment inside the page: upper bits stay, low bits wrap.
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  // Increment across the whole space, wrapping at the top.
  function automatic logic [ADDR_W-1:0] lin_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_hi_i) begin
      addr_q[ADDR_W-1:8] <= byte_i[HI_W-1:0];
    end else if (ld_lo_i) begin
      addr_q[7:0] <= byte_i;
    end else if (step_page_i) begin
      addr_q <= page_step(addr_q);
    end else if (step_lin_i) begin
      addr_q <= lin_step(addr_q);
    end
  end

  assign addr_o = addr_q;

  // R6: a page step never disturbs the page number.
  p_page_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_page_i |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

  // R9: a linear step from the top address lands on zero.
  p_top_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_lin_i && !ld_hi_i && !ld_lo_i && !step_page_i && (&addr_o)) |=> (addr_o == '0));

endmodule

// File: rtl/tw_eeprom_slave.sv
`timescale 1ns/1ps
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         PAGE_W      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] FAMILY      = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);

  // Line events
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  // Engine state
  phase_t      phase;
  logic [3:0]  bitcnt;
  logic [6:0]  rx_sh;
  logic [7:0]  tx_sh;
  logic        ack_pend;
  logic        tx_go;
  logic        oe_q;
  logic        wrote_any;
  logic [ADDR_W-1:0] addr;

  // Named internal events
  logic       receiving, active;
  logic [7:0] rx_byte;
  logic       byte_done, ack_clk, dev_done, dev_ok;
  logic       ld_hi, ld_lo, step_page, step_lin;

  assign active    = (phase != PH_IDLE) && (phase != PH_WAIT);
  assign receiving = (phase == PH_DEV) || (phase == PH_AHI) ||
                     (phase == PH_ALO) || (phase == PH_WDATA);
  assign rx_byte   = {rx_sh, sda_s};
  assign byte_done = scl_rise && receiving && (bitcnt == BIT_LAST);
  assign ack_clk   = scl_rise && active && (bitcnt == ACK_SLOT);
  assign dev_done  = byte_done && (phase == PH_DEV);
  assign dev_ok    = dev_hit(rx_byte, FAMILY, strap_i) && !busy_i;

  assign ld_hi     = byte_done && (phase == PH_AHI);
  assign ld_lo     = byte_done && (phase == PH_ALO);
  assign step_page = byte_done && (phase == PH_WDATA);
  assign step_lin  = ack_clk && (phase == PH_READ) && !ack_pend;

  tw_word_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_hi_i     (ld_hi),
    .ld_lo_i     (ld_lo),
    .byte_i      (rx_byte),
    .step_page_i (step_page),
    .step_lin_i  (step_lin),
    .addr_o      (addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      bitcnt      <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      ack_pend    <= 1'b0;
      tx_go       <= 1'b0;
      oe_q        <= 1'b0;
      wrote_any   <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_evt) begin
        phase     <= PH_DEV;
        bitcnt    <= '0;
        oe_q      <= 1'b0;
        ack_pend  <= 1'b0;
        tx_go     <= 1'b0;
        wrote_any <= 1'b0;
      end else if (stop_evt) begin
        if (phase == PH_WDATA && wrote_any) wr_commit_o <= 1'b1;
        phase     <= PH_IDLE;
        oe_q      <= 1'b0;
        ack_pend  <= 1'b0;
        tx_go     <= 1'b0;
        wrote_any <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bitcnt == ACK_SLOT) begin
            bitcnt   <= '0;
            ack_pend <= 1'b0;
            if (phase == PH_READ) begin
              if (ack_pend || !sda_s) begin
                tx_go <= 1'b1;
              end else begin
                tx_go <= 1'b0;
                phase <= PH_WAIT;
              end
            end
          end else begin
            bitcnt <= bitcnt + 4'd1;
            if (receiving) rx_sh <= rx_byte[6:0];
            if (byte_done) begin
              unique case (phase)
                PH_DEV: begin
                  if (dev_ok) begin
                    ack_pend <= 1'b1;
                    phase    <= rx_byte[0] ? PH_READ : PH_AHI;
                  end else begin
                    phase <= PH_WAIT;
                  end
                end
                PH_AHI: begin
                  ack_pend <= 1'b1;
                  phase    <= PH_ALO;
                end
                PH_ALO: begin
                  ack_pend <= 1'b1;
                  phase    <= PH_WDATA;
                end
                default: begin
                  ack_pend   <= 1'b1;
                  wr_valid_o <= !wp_i;
                  wrote_any  <= wrote_any | !wp_i;
                  wr_addr_o  <= addr;
                  wr_data_o  <= rx_byte;
                end
              endcase
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == ACK_SLOT) begin
            oe_q <= ack_pend;
          end else if (phase == PH_READ && bitcnt == 4'd0 && tx_go) begin
            oe_q  <= ~rd_data_i[7];
            tx_sh <= {rd_data_i[6:0], 1'b0};
            tx_go <= 1'b0;
          end else if (phase == PH_READ && bitcnt != 4'd0) begin
            oe_q  <= ~tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end else begin
            oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign rd_addr_o = addr;

  // R1: a stop leaves the engine idle and off the bus.
  p_stop_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe_o && phase == PH_IDLE));

  // R3: while unselected the data line is never pulled.
  p_quiet_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_WAIT) |-> !sda_oe_o);

  // R4: a busy write engine turns the address byte away.
  p_busy_refuses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy_i) |=> (phase == PH_WAIT));

  // R7: a commit only ever follows a stop.
  p_commit_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_evt));

  // R11: the output enable moves only after a falling clock, start or stop.
  p_oe_moves_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_evt || stop_evt));

endmodule

// File: tb/tw_eeprom_slave_test.sv
`timescale 1ns/1ps
module tw_eeprom_slave_test;

  localparam int AW = 15;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic busy = 1'b0;
  logic sda_oe;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic wr_valid, wr_commit;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic bus_sda;

  int vecs = 0;
  int fails = 0;
  int exp_commits = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  logic [AW+7:0] wq[$];

  always #4 clk = ~clk;

  assign bus_sda = m_sda & ~sda_oe;

  tw_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .strap_i(strap), .wp_i(wp), .busy_i(busy), .sda_oe_o(sda_oe),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  // Memory content model: a fixed function of the address.
  function automatic logic [7:0] fdat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction

  always @(posedge clk) rd_data <= fdat(rd_addr);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Every-clock comparison against the reference queue and quiet windows.
  always @(negedge clk) begin
    logic [AW+7:0] e;
    if (rst_n) begin
      if (wr_valid) begin
        if (wq.size() == 0) chk(1'b0, "R5/R7 unexpected write pulse", {wr_addr, wr_data}, 0);
        else begin
          e = wq.pop_front();
          chk({wr_addr, wr_data} == e, "R5 write address/data", {wr_addr, wr_data}, e);
        end
      end
      if (wr_commit) begin
        chk(exp_commits > 0, "R7 commit pulse", 1, exp_commits);
        if (exp_commits > 0) exp_commits--;
      end
      if (quiet) chk(sda_oe == 1'b0, "R3 SDA released", sda_oe, 0);
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b1; hw(H);
  endtask

  task automatic send_bit(input bit b);
    hw(2);
    m_sda = b; hw(H);
    m_scl = 1'b1; hw(H);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit chk_win, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    hw(2);
    m_sda = 1'b1; hw(H);
    if (chk_win && exp_ack) chk(sda_oe == 1'b1, "R11 ack driven before 9th clock", sda_oe, 1);
    m_scl = 1'b1; hw(H/2);
    got = (bus_sda == 1'b0);
    chk(got == exp_ack, req, got, exp_ack);
    hw(H/2);
    m_scl = 1'b0;
    if (chk_win) begin
      hw(H/2);
      chk(sda_oe == 1'b0, "R11 ack released after 9th clock", sda_oe, 0);
    end
  endtask

  task automatic recv_byte(input bit m_ack, input logic [7:0] exp, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hw(H);
      m_scl = 1'b1; hw(H/2);
      got[i] = bus_sda;
      hw(H/2);
      m_scl = 1'b0;
    end
    chk(got == exp, req, got, exp);
    send_bit(!m_ack);
    hw(2);
    m_sda = 1'b1;
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d);
    wq.push_back({a, d});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): ran %0d cycles, expected fewer", 150000);
    finish_run();
  end

  initial begin
    hw(5);
    rst_n = 1'b1;
    hw(5);
    // R1: idle after reset
    chk(sda_oe == 1'b0, "R1 reset SDA released", sda_oe, 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R1 reset no write pulses", {wr_valid, wr_commit}, 0);

    // R2 R5 R7: three-byte write at 0x1234
    do_start();
    send_byte(8'hAA, 1'b1, 1'b1, "R2 device address ack (write)");
    send_byte(8'h12, 1'b1, 1'b1, "R5 high word address ack");
    send_byte(8'h34, 1'b1, 1'b1, "R5 low word address ack");
    push_wr(15'h1234, 8'hA1); send_byte(8'hA1, 1'b1, 1'b1, "R5 data ack 0");
    push_wr(15'h1235, 8'hB2); send_byte(8'hB2, 1'b1, 1'b1, "R5 data ack 1");
    push_wr(15'h1236, 8'hC3); send_byte(8'hC3, 1'b1, 1'b1, "R5 data ack 2");
    exp_commits++;
    do_stop();
    hw(H);
    chk(exp_commits == 0, "R7 commit after stop", exp_commits, 0);

    // R8: current address read continues after last write
    do_start();
    send_byte(8'hAB, 1'b1, 1'b0, "R2 device address ack (read)");
    recv_byte(1'b0, fdat(15'h1237), "R8 current address data");
    quiet = 1'b1; hw(H);
    quiet = 1'b0;
    do_stop();

    // R4: busy refuses, then polling succeeds
    busy = 1'b1;
    do_start();
    send_byte(8'hAA, 1'b0, 1'b0, "R4 no ack while busy");
    quiet = 1'b1;
    send_byte(8'h00, 1'b0, 1'b0, "R3 ignored after refusal");
    do_stop();
    quiet = 1'b0;
    busy = 1'b0;
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R4 ack after busy drops");
    send_byte(8'h00, 1'b1, 1'b1, "R5 high address after poll");
    send_byte(8'h10, 1'b1, 1'b1, "R5 low address after poll");
    do_stop();

    // R3: mismatched straps
    do_start();
    send_byte(8'hA0, 1'b0, 1'b0, "R3 no ack on strap mismatch");
    quiet = 1'b1;
    send_byte(8'h3C, 1'b0, 1'b0, "R3 later byte ignored");
    do_stop();
    quiet = 1'b0;

    // R6: page wrap during write
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R2 ack");
    send_byte(8'h00, 1'b1, 1'b1, "R5 high address");
    send_byte(8'h3E, 1'b1, 1'b1, "R5 low address");
    push_wr(15'h003E, 8'h11); send_byte(8'h11, 1'b1, 1'b1, "R6 data at 3E");
    push_wr(15'h003F, 8'h22); send_byte(8'h22, 1'b1, 1'b1, "R6 data at 3F");
    push_wr(15'h0000, 8'h33); send_byte(8'h33, 1'b1, 1'b1, "R6 wrapped to page start");
    exp_commits++;
    do_stop();
    do_start();
    send_byte(8'hAB, 1'b1, 1'b0, "R2 ack");
    recv_byte(1'b0, fdat(15'h0001), "R6 address after page wrap");
    do_stop();

    // R9 R10: random read near the top, sequential across the wrap
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R10 dummy write ack");
    send_byte(8'h7F, 1'b1, 1'b1, "R10 high address");
    send_byte(8'hFE, 1'b1, 1'b1, "R10 low address");
    do_start();
    send_byte(8'hAB, 1'b1, 1'b0, "R10 read ack after repeated start");
    recv_byte(1'b1, fdat(15'h7FFE), "R10 random read data");
    recv_byte(1'b1, fdat(15'h7FFF), "R8 sequential next byte");
    recv_byte(1'b0, fdat(15'h0000), "R9 wrap to address 0");
    quiet = 1'b1; hw(H);
    quiet = 1'b0;
    do_stop();

    // R7: write protect
    wp = 1'b1;
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R7 ack with protect");
    send_byte(8'h01, 1'b1, 1'b1, "R7 high address");
    send_byte(8'h00, 1'b1, 1'b1, "R7 low address");
    send_byte(8'h5A, 1'b1, 1'b1, "R7 protected data acked");
    send_byte(8'hA5, 1'b1, 1'b1, "R7 protected data acked");
    do_stop();
    hw(H);
    wp = 1'b0;

    // R1: start in the middle of a byte keeps the word address
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R1 ack before abort");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    do_start();
    send_byte(8'hAB, 1'b1, 1'b0, "R1 ack after mid-byte start");
    recv_byte(1'b0, fdat(15'h0102), "R1 word address kept");
    do_stop();

    // R12: recovery sequence
    do_start();
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    do_start();
    do_stop();
    hw(2*H);
    quiet = 1'b0;
    do_start();
    send_byte(8'hAB, 1'b1, 1'b0, "R12 ack after recovery");
    recv_byte(1'b0, fdat(15'h0103), "R12 read after recovery");
    do_stop();

    hw(2*H);
    chk(wq.size() == 0, "R5 all expected writes seen", wq.size(), 0);
    chk(exp_commits == 0, "R7 no pending commit", exp_commits, 0);
    finish_run();
  end

endmodule